// File: doc/BRIEF.md
# Ethernet Tail Tag Codec

This block sits between a host MAC stream and the host-facing port of a small three-port switch. It adds and strips a single trailer byte that carries port steering. Frames travelling toward the switch get one extra byte after their last payload byte. That byte is one-hot and names the egress port. Frames arriving from the switch lose their final byte. The low three bits of that byte are reported as the binary number of the ingress port.

Both directions use byte-wide valid/ready/last streams. The transmit input carries a port-index sideband, and the receive output carries a source-port sideband. A single enable input turns tagging on or off. While it is low, frames pass through untouched in both directions. The enable value is taken at the first beat of each frame, so changing it never splits a frame. Frame check sequences, padding, MAC framing and forwarding decisions belong to other blocks.

Top module: `tail_tag_codec`

## Requirements
- R1: After reset, and while reset is asserted, no output beat is valid unless an input beat is offered. The receive input is ready, and the transmit input ready follows the transmit output ready.
- R2: With tagging on, a transmit frame of N bytes leaves as N unchanged payload beats with last low, then one tag beat with last high. The tag byte has only bit P set, where P is the port index.
- R3: While the tag beat is waiting, the transmit input ready is low. With the output always ready, the input ready is low for exactly one cycle per tagged frame and never low when tagging is off.
- R4: The transmit port index is captured on the first beat of a frame. Changes on the port input during later beats do not change the tag.
- R5: With tagging on, a receive frame of N>1 bytes leaves as its first N-1 bytes, with last on byte N-1. The source-port output equals bits [2:0] of byte N on that last beat and is zero on the other beats.
- R6: With tagging on, a one-byte receive frame is accepted and produces no output beat.
- R7: With tagging off, frames pass unchanged in both directions with the same last marking, no tag beat is added, and the source-port output is zero.
- R8: The enable is sampled on the first beat of each frame. A change later in the frame takes effect from the next frame on.
- R9: Output beats are neither lost nor duplicated under output backpressure. A stalled tag beat keeps its value until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_en | input | 1 | Tagging enable, sampled per frame |
| tx_in_data | input | 8 | Host transmit byte |
| tx_in_valid | input | 1 | Host transmit beat valid |
| tx_in_ready | output | 1 | Host transmit beat accepted |
| tx_in_last | input | 1 | Final payload byte of the frame |
| tx_in_port | input | 2 | Egress port index, read on the first beat |
| tx_out_data | output | 8 | Byte toward the switch |
| tx_out_valid | output | 1 | Switch-side beat valid |
| tx_out_ready | input | 1 | Switch side accepts the beat |
| tx_out_last | output | 1 | Final byte toward the switch (the tag when tagging) |
| rx_in_data | input | 8 | Byte from the switch |
| rx_in_valid | input | 1 | Switch receive beat valid |
| rx_in_ready | output | 1 | Switch receive beat accepted |
| rx_in_last | input | 1 | Final byte from the switch (the tag when tagging) |
| rx_out_data | output | 8 | Payload byte toward the host |
| rx_out_valid | output | 1 | Host receive beat valid |
| rx_out_ready | input | 1 | Host accepts the beat |
| rx_out_last | output | 1 | Final payload byte toward the host |
| rx_out_port | output | 3 | Source port number, valid on the last beat |

## Verification
The hardest state to reach is a tag beat held under backpressure on one side while the enable changes partway through a frame. Neither condition shows at the ports until the end of the frame. The stimulus table flips the enable after the first beat, and the port index as well. It also drops the output ready on a fixed period, so the stall sometimes lands on the tag beat or on the receive hold byte. A directed case then parks the tag beat with the output not ready for several cycles and applies reset while the tag is still pending.

// File: rtl/tail_tag_pkg.sv
package tail_tag_pkg;

  typedef enum logic {
    INS_PASS = 1'b0,
    INS_TAG  = 1'b1
  } ins_state_e;

endpackage

// File: rtl/tail_tag_frame_latch.sv
module tail_tag_frame_latch #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beat,
  input  logic         last,
  input  logic [W-1:0] d,
  output logic         sof,
  output logic [W-1:0] q
);

  logic         sof_q, sof_d;
  logic         load;
  logic [W-1:0] q_r;

  always_comb begin
    sof_d = sof_q;
    if (beat) sof_d = last;
    load = beat & sof_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_q <= 1'b1;
      q_r   <= '0;
    end else begin
      sof_q <= sof_d;
      if (load) q_r <= d;
    end
  end

  assign sof = sof_q;
  assign q   = q_r;

endmodule

// File: rtl/tail_tag_inserter.sv
module tail_tag_inserter
  import tail_tag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  input  logic [PORT_W-1:0] in_port,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic              tag_busy,
  output logic [PORT_W-1:0] port_hold
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  ins_state_e          state_q, state_d;
  logic                sof;
  logic [PORT_W:0]     fr_q;
  logic                fr_en;
  logic [PORT_W-1:0]   port_q;
  logic [DATA_W-1:0]   tag_byte;
  logic                beat;

  assign beat = in_valid & in_ready;

  tail_tag_frame_latch #(.W(PORT_W + 1)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .last  (in_last),
    .d     ({tag_en, in_port}),
    .sof   (sof),
    .q     (fr_q)
  );

  assign fr_en    = sof ? tag_en : fr_q[PORT_W];
  assign port_q   = fr_q[PORT_W-1:0];
  assign tag_byte = ONE << port_q;

  always_comb begin
    state_d   = state_q;
    out_data  = in_data;
    out_valid = in_valid;
    out_last  = in_last & ~fr_en;
    in_ready  = out_ready;
    if (state_q == INS_TAG) begin
      out_data  = tag_byte;
      out_valid = 1'b1;
      out_last  = 1'b1;
      in_ready  = 1'b0;
      if (out_ready) state_d = INS_PASS;
    end else if (in_valid && out_ready && in_last && fr_en) begin
      state_d = INS_TAG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= INS_PASS;
    else        state_q <= state_d;
  end

  assign tag_busy  = (state_q == INS_TAG);
  assign port_hold = port_q;

endmodule

// File: rtl/tail_tag_extractor.sv
module tail_tag_extractor #(
  parameter int DATA_W = 8,
  parameter int SRC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic [SRC_W-1:0]  out_port,
  output logic              fr_en,
  output logic              hold_vld
);

  logic              sof;
  logic              en_q;
  logic              beat;
  logic              hold_vld_q, hold_vld_d;
  logic [DATA_W-1:0] hold_data_q;
  logic              hold_load;

  assign beat = in_valid & in_ready;

  tail_tag_frame_latch #(.W(1)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .last  (in_last),
    .d     (tag_en),
    .sof   (sof),
    .q     (en_q)
  );

  assign fr_en = sof ? tag_en : en_q;

  always_comb begin
    hold_vld_d = hold_vld_q;
    hold_load  = 1'b0;
    if (fr_en) begin
      out_valid = hold_vld_q & in_valid;
      out_data  = hold_data_q;
      out_last  = in_last;
      out_port  = in_last ? in_data[SRC_W-1:0] : '0;
      in_ready  = ~hold_vld_q | out_ready;
      if (beat) begin
        if (in_last) begin
          hold_vld_d = 1'b0;
        end else begin
          hold_vld_d = 1'b1;
          hold_load  = 1'b1;
        end
      end
    end else begin
      out_valid = in_valid;
      out_data  = in_data;
      out_last  = in_last;
      out_port  = '0;
      in_ready  = out_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q  <= 1'b0;
      hold_data_q <= '0;
    end else begin
      hold_vld_q <= hold_vld_d;
      if (hold_load) hold_data_q <= in_data;
    end
  end

  assign hold_vld = hold_vld_q;

endmodule

// File: rtl/tail_tag_codec.sv
module tail_tag_codec #(
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 3,
  parameter int SRC_W     = 3,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic [DATA_W-1:0] tx_in_data,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic              tx_in_last,
  input  logic [PORT_W-1:0] tx_in_port,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic              tx_out_last,
  input  logic [DATA_W-1:0] rx_in_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic              rx_in_last,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic              rx_out_last,
  output logic [SRC_W-1:0]  rx_out_port
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              tx_tag_busy;
  logic [PORT_W-1:0] tx_port_hold;
  logic              rx_fr_en;
  logic              rx_hold_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  tail_tag_inserter #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_ins (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tag_en    (tag_en),
    .in_data   (tx_in_data),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_last   (tx_in_last),
    .in_port   (tx_in_port),
    .out_data  (tx_out_data),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_last  (tx_out_last),
    .tag_busy  (tx_tag_busy),
    .port_hold (tx_port_hold)
  );

  tail_tag_extractor #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_ext (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tag_en    (tag_en),
    .in_data   (rx_in_data),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_last   (rx_in_last),
    .out_data  (rx_out_data),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_last  (rx_out_last),
    .out_port  (rx_out_port),
    .fr_en     (rx_fr_en),
    .hold_vld  (rx_hold_vld)
  );

endmodule

// File: rtl/tail_tag_codec_chk.sv
module tail_tag_codec_chk #(
  parameter int DATA_W = 8,
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] tx_out_data,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic              tx_out_last,
  input logic              tx_in_valid,
  input logic              tx_in_ready,
  input logic              tx_in_last,
  input logic              tx_tag_busy,
  input logic [PORT_W-1:0] tx_port_hold,
  input logic              rx_fr_en,
  input logic              rx_hold_vld,
  input logic              rx_out_valid,
  input logic              rx_in_valid,
  input logic              rx_in_ready,
  input logic              rx_in_last
);

  logic tx_in_frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_in_frame_q <= 1'b0;
    else if (tx_in_valid && tx_in_ready) tx_in_frame_q <= ~tx_in_last;
  end

  // R2: the pending tag beat is a single set bit marked last
  p_tag_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tag_busy |-> (tx_out_valid && tx_out_last && $countones(tx_out_data) == 1));

  // R3: input stalled while the tag is out
  p_tag_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tag_busy |-> !tx_in_ready);

  // R3: an accepted tag frees the input on the next cycle
  p_tag_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag_busy && tx_out_ready) |=> !tx_tag_busy);

  // R4: the captured port does not move inside a frame
  p_port_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_frame_q |=> $stable(tx_port_hold));

  // R9: a stalled tag keeps its value
  p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag_busy && !tx_out_ready) |=> (tx_tag_busy && $stable(tx_out_data)));

  // R6: nothing leaves the receive side while the hold byte is empty
  p_rx_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fr_en && !rx_hold_vld) |-> !rx_out_valid);

  // R5: the trailer byte empties the hold register
  p_rx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fr_en && rx_in_valid && rx_in_ready && rx_in_last) |=> !rx_hold_vld);

endmodule

bind tail_tag_codec tail_tag_codec_chk #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_out_data  (tx_out_data),
  .tx_out_valid (tx_out_valid),
  .tx_out_ready (tx_out_ready),
  .tx_out_last  (tx_out_last),
  .tx_in_valid  (tx_in_valid),
  .tx_in_ready  (tx_in_ready),
  .tx_in_last   (tx_in_last),
  .tx_tag_busy  (tx_tag_busy),
  .tx_port_hold (tx_port_hold),
  .rx_fr_en     (rx_fr_en),
  .rx_hold_vld  (rx_hold_vld),
  .rx_out_valid (rx_out_valid),
  .rx_in_valid  (rx_in_valid),
  .rx_in_ready  (rx_in_ready),
  .rx_in_last   (rx_in_last)
);

// File: tb/tail_tag_codec_bench.sv
module tail_tag_codec_bench;

  typedef struct packed {
    logic       dir;      // 0 transmit, 1 receive
    logic       en;
    logic       flip;     // invert enable after the first beat
    logic [4:0] len;
    logic [1:0] port;
    logic [2:0] stall;    // output ready low every stall-th cycle, 0 = never
    logic [7:0] base;
    logic [5:0] exp_cnt;
    logic [7:0] exp_tp;   // tag byte (transmit) or source port (receive)
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 5'd4, 2'd0, 3'd0, 8'h10, 6'd5, 8'h01},
    '{1'b0, 1'b1, 1'b0, 5'd1, 2'd2, 3'd0, 8'h20, 6'd2, 8'h04},
    '{1'b0, 1'b1, 1'b0, 5'd6, 2'd1, 3'd3, 8'h30, 6'd7, 8'h02},
    '{1'b0, 1'b0, 1'b0, 5'd3, 2'd1, 3'd0, 8'h38, 6'd3, 8'h00},
    '{1'b0, 1'b1, 1'b1, 5'd3, 2'd2, 3'd0, 8'h40, 6'd4, 8'h04},
    '{1'b0, 1'b0, 1'b1, 5'd3, 2'd0, 3'd0, 8'h48, 6'd3, 8'h00},
    '{1'b0, 1'b1, 1'b0, 5'd2, 2'd3, 3'd2, 8'h90, 6'd3, 8'h08},
    '{1'b1, 1'b1, 1'b0, 5'd5, 2'd0, 3'd0, 8'h28, 6'd4, 8'h04},
    '{1'b1, 1'b1, 1'b0, 5'd1, 2'd0, 3'd0, 8'h57, 6'd0, 8'h00},
    '{1'b1, 1'b1, 1'b0, 5'd2, 2'd0, 3'd2, 8'h61, 6'd1, 8'h02},
    '{1'b1, 1'b0, 1'b0, 5'd3, 2'd0, 3'd0, 8'h50, 6'd3, 8'h00},
    '{1'b1, 1'b1, 1'b1, 5'd4, 2'd0, 3'd2, 8'h70, 6'd3, 8'h03},
    '{1'b1, 1'b0, 1'b1, 5'd2, 2'd0, 3'd0, 8'h80, 6'd2, 8'h00},
    '{1'b1, 1'b1, 1'b0, 5'd6, 2'd0, 3'd3, 8'hA1, 6'd5, 8'h06}
  };

  logic       clk;
  logic       rst_n;
  logic       tag_en;
  logic [7:0] tx_in_data;
  logic       tx_in_valid;
  logic       tx_in_ready;
  logic       tx_in_last;
  logic [1:0] tx_in_port;
  logic [7:0] tx_out_data;
  logic       tx_out_valid;
  logic       tx_out_ready;
  logic       tx_out_last;
  logic [7:0] rx_in_data;
  logic       rx_in_valid;
  logic       rx_in_ready;
  logic       rx_in_last;
  logic [7:0] rx_out_data;
  logic       rx_out_valid;
  logic       rx_out_ready;
  logic       rx_out_last;
  logic [2:0] rx_out_port;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [7:0] cap_d [64];
  logic       cap_l [64];
  logic [2:0] cap_p [64];
  int         ncap;
  int         nstall;

  tail_tag_codec u_tail_tag_codec (
    .clk          (clk),
    .rst_n        (rst_n),
    .tag_en       (tag_en),
    .tx_in_data   (tx_in_data),
    .tx_in_valid  (tx_in_valid),
    .tx_in_ready  (tx_in_ready),
    .tx_in_last   (tx_in_last),
    .tx_in_port   (tx_in_port),
    .tx_out_data  (tx_out_data),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .tx_out_last  (tx_out_last),
    .rx_in_data   (rx_in_data),
    .rx_in_valid  (rx_in_valid),
    .rx_in_ready  (rx_in_ready),
    .rx_in_last   (rx_in_last),
    .rx_out_data  (rx_out_data),
    .rx_out_valid (rx_out_valid),
    .rx_out_ready (rx_out_ready),
    .rx_out_last  (rx_out_last),
    .rx_out_port  (rx_out_port)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input vec_t v);
    int  idx;
    int  k;
    int  tail;
    bit  rdy;
    bit  acc;
    idx = 0; k = 0; tail = 0; ncap = 0; nstall = 0;
    while (tail < 6) begin
      @(negedge clk);
      rdy    = (v.stall == 0) || ((k % int'(v.stall)) != 0);
      tag_en = (v.flip && idx > 0) ? ~v.en : v.en;
      if (!v.dir) begin
        tx_in_valid  = (idx < int'(v.len));
        tx_in_data   = 8'(int'(v.base) + idx);
        tx_in_last   = (idx == int'(v.len) - 1);
        tx_in_port   = (idx == 0) ? v.port : (v.port ^ 2'd1);
        tx_out_ready = rdy;
      end else begin
        rx_in_valid  = (idx < int'(v.len));
        rx_in_data   = 8'(int'(v.base) + idx);
        rx_in_last   = (idx == int'(v.len) - 1);
        rx_out_ready = rdy;
      end
      #1;
      if (!v.dir) begin
        if (tx_out_valid && tx_out_ready && ncap < 64) begin
          cap_d[ncap] = tx_out_data; cap_l[ncap] = tx_out_last; cap_p[ncap] = 3'd0; ncap++;
        end
        if (!tx_in_ready && tx_out_ready) nstall++;
        acc = tx_in_valid && tx_in_ready;
      end else begin
        if (rx_out_valid && rx_out_ready && ncap < 64) begin
          cap_d[ncap] = rx_out_data; cap_l[ncap] = rx_out_last; cap_p[ncap] = rx_out_port; ncap++;
        end
        acc = rx_in_valid && rx_in_ready;
      end
      if (acc) idx++;
      if (idx >= int'(v.len)) tail++;
      k++;
    end
    tx_in_valid = 1'b0;
    rx_in_valid = 1'b0;
    tx_out_ready = 1'b1;
    rx_out_ready = 1'b1;
  endtask

  function automatic string req_of(input vec_t v);
    if (v.flip)          return "R8";
    if (v.stall != 0)    return "R9";
    if (!v.en)           return "R7";
    if (!v.dir)          return "R2";
    if (v.len == 5'd1)   return "R6";
    return "R5";
  endfunction

  task automatic check_frame(input vec_t v);
    string req;
    int    n;
    logic [7:0] ed;
    logic       el;
    logic [2:0] ep;
    req = req_of(v);
    chk(ncap == int'(v.exp_cnt), req, ncap, int'(v.exp_cnt));
    n = (ncap < int'(v.exp_cnt)) ? ncap : int'(v.exp_cnt);
    for (int i = 0; i < n; i++) begin
      ed = 8'(int'(v.base) + i);
      el = (i == int'(v.exp_cnt) - 1);
      ep = 3'd0;
      if (!v.dir && v.en && i == int'(v.len)) ed = v.exp_tp;
      if (v.dir && v.en && el) ep = v.exp_tp[2:0];
      chk(cap_d[i] == ed, (!v.dir && v.en && el) ? "R4" : req, int'(cap_d[i]), int'(ed));
      chk(cap_l[i] == el, req, int'(cap_l[i]), int'(el));
      chk(cap_p[i] == ep, v.dir ? "R5" : req, int'(cap_p[i]), int'(ep));
    end
    if (!v.dir && v.stall == 0)
      chk(nstall == (v.en ? 1 : 0), "R3", nstall, v.en ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0; tag_en = 1'b1;
    tx_in_data = '0; tx_in_valid = 1'b0; tx_in_last = 1'b0; tx_in_port = '0; tx_out_ready = 1'b1;
    rx_in_data = '0; rx_in_valid = 1'b0; rx_in_last = 1'b0; rx_out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: idle outputs while in reset
    chk(tx_out_valid == 1'b0, "R1", int'(tx_out_valid), 0);
    chk(rx_out_valid == 1'b0, "R1", int'(rx_out_valid), 0);
    chk(rx_in_ready == 1'b1, "R1", int'(rx_in_ready), 1);
    chk(tx_in_ready == 1'b1, "R1", int'(tx_in_ready), 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(tx_out_valid == 1'b0 && rx_out_valid == 1'b0, "R1", int'({tx_out_valid, rx_out_valid}), 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VECS[v]);
      check_frame(VECS[v]);
    end

    // R9 / R3: tag beat parked under backpressure
    @(negedge clk);
    tag_en = 1'b1; tx_in_valid = 1'b1; tx_in_data = 8'hAA; tx_in_last = 1'b1;
    tx_in_port = 2'd1; tx_out_ready = 1'b1;
    #1;
    chk(tx_in_ready == 1'b1 && tx_out_last == 1'b0, "R2", int'({tx_in_ready, tx_out_last}), 2);
    @(negedge clk);
    tx_in_valid = 1'b0; tx_out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(tx_out_valid && tx_out_last && tx_out_data == 8'h02, "R9", int'(tx_out_data), 8'h02);
      chk(tx_in_ready == 1'b0, "R3", int'(tx_in_ready), 0);
      @(negedge clk);
    end
    // R1: reset while the tag is pending clears it
    rst_n = 1'b0;
    #1;
    chk(tx_out_valid == 1'b0, "R1", int'(tx_out_valid), 0);
    chk(rx_in_ready == 1'b1, "R1", int'(rx_in_ready), 1);
    @(negedge clk) rst_n = 1'b1;
    tx_out_ready = 1'b1;
    repeat (4) @(negedge clk);

    // R6 after reset: a lone trailer byte, then a normal frame still intact
    run_frame(VECS[8]);
    check_frame(VECS[8]);
    run_frame(VECS[7]);
    check_frame(VECS[7]);

    finish_run();
  end

endmodule